// File: doc/BRIEF.md
# Operand Addressing Bus-Cycle Sequencer

This block drives the memory bus of an 8-bit processor core through the operand phase of one instruction. Once an instruction is launched, it produces a cycle-by-cycle trace: the address, a read/write strobe and an internal-idle flag. It fetches operand and address bytes from the bus, forms the effective address for the selected addressing mode, captures the operand, and raises a done pulse on the final cycle. Instruction decoding, the ALU and the flags sit outside the block. The decoder supplies an addressing-mode code, an operation class, the index registers, the program counter, a page-select flag and the byte to be stored.

Every memory-destination operation reads its target before writing it, including a plain move. Idle cycles sit at fixed positions within each mode, so the exact length and content of every trace is part of the contract. A direct-page address is the page flag placed above an 8-bit offset. Indexed direct-page addresses and direct-page pointer bytes wrap inside that 256-byte page. Mode codes above 8 run the immediate trace.

The control is a single state machine with these states:

- WAIT: idle, ready for a launch.
- OPC: opcode read.
- IMM: immediate byte read.
- OFF: direct offset read.
- ALO and AHI: absolute address bytes read.
- GAP1 and GAP2: internal idle cycles.
- PLO and PHI: pointer bytes read.
- RD: target read.
- WR: target write.
- TAIL: trailing idle cycle.

Its transitions are as follows:

- WAIT goes to OPC when start is high.
- OPC goes to IMM for immediate mode.
- OPC goes to OFF for the four direct-page-offset modes.
- OPC goes to GAP1 for the two X-indirect modes.
- OPC goes to ALO for the two absolute modes.
- OFF goes to RD for direct mode, to GAP1 for direct indexed and indexed indirect, and to PLO for indirect indexed.
- ALO goes to AHI.
- AHI goes to RD for absolute mode and to GAP1 for absolute indexed.
- GAP1 goes to PLO for indexed indirect, to GAP2 for the auto-increment store, and otherwise to RD.
- GAP2 goes to WR.
- PLO goes to PHI.
- PHI goes to RD for indexed indirect and to GAP1 for indirect indexed.
- RD goes to WR for a store, to TAIL for a compare or an auto-increment load, and otherwise to WAIT.
- IMM, WR and TAIL go to WAIT.

Top module: `oas_seq`

## Requirements
- R1: A launch is a high `start` while the block is idle. The inputs are sampled at that launch. The first cycle after the launch is a read at `pc`, with `rw`=1 and `idle`=0.
- R2: Mode 0 (immediate) with class 0 (load) lasts 2 cycles. The second cycle reads `pc`+1, and `operand` then holds the byte read there.
- R3: Mode 1 (direct) lasts 3 cycles. They are the opcode read, the offset read at `pc`+1, and the data read at {7'b0, `page`, offset}.
- R4: Mode 2 (direct indexed) inserts one idle cycle after the offset read, so the data read falls on cycle 4. It reads at offset+index wrapped to 8 bits inside the page. `idx_sel`=0 selects X and `idx_sel`=1 selects Y.
- R5: Mode 3 (indirect through X) lasts 3 cycles: opcode, idle, then the data read at {page, X}.
- R6: Mode 5 (indexed indirect) lasts 6 cycles:
  - opcode read;
  - offset read;
  - idle cycle;
  - pointer low byte read at page:(offset+X);
  - pointer high byte read at page:(offset+X+1), which wraps in the page;
  - data read at the pointer.
- R7: Mode 6 (indirect indexed) lasts 6 cycles:
  - opcode read;
  - offset read;
  - pointer low byte read at page:offset;
  - pointer high byte read at page:(offset+1);
  - idle cycle;
  - data read at pointer+Y, a full 16-bit sum.
- R8: Mode 7 (absolute) lasts 4 cycles: opcode, address low at `pc`+1, address high at `pc`+2, then data. Mode 8 (absolute indexed) lasts 5 cycles, with an idle cycle before the data read at address+index.
- R9: Class 1 (store) reads the target and then writes the same address on the next cycle with `rw`=0 and `wdata`=`st_data`. This costs one cycle more than the load.
- R10: Mode 4 (auto-increment through X) works in two ways. As a store it runs opcode, idle, idle, then one write at {page, X} with no earlier read of the target. As a load it runs opcode, idle, the read at {page, X}, then an idle cycle.
- R11: Class 2 (compare) reads the target and then ends on an idle cycle instead of a write. `rw` stays 1 for the whole trace.
- R12: `rw` is 1 on every read and every idle cycle. `idle` is 1 exactly on the idle cycles and while waiting.
- R13: `done` is high for exactly the final cycle of each trace. A `start` raised during a trace is ignored.
- R14: While `rst_n` is low and after its release, the block waits with `done`=0, `rw`=1 and `idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, honoured only while idle |
| mode | input | 4 | Addressing-mode code |
| op_cls | input | 2 | 0 load, 1 store, 2 compare |
| idx_sel | input | 1 | Index for modes 2 and 8: 0 is X, 1 is Y |
| pc | input | 16 | Address of the opcode byte |
| page | input | 1 | Direct-page select |
| x_reg | input | 8 | X index register |
| y_reg | input | 8 | Y index register |
| st_data | input | 8 | Byte to write on a store |
| rdata | input | 8 | Read-data bus |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 read or idle, 0 write |
| idle | output | 1 | Internal idle cycle flag |
| wdata | output | 8 | Write-data bus |
| operand | output | 8 | Last byte read as operand |
| done | output | 1 | High on the final cycle of a trace |

## Verification
Trace cycle k (k = 1 being the opcode read) shows on the ports k clock edges after the edge that sampled `start`. The bench drives `start` on a falling edge and compares the address, strobe, idle flag and `done` of that cycle on the k-th falling edge after it. `operand` is registered at the end of the data-read cycle, so the bench reads it one falling edge after `done`, while the block is waiting again. Expected traces are built in the bench from the mode rules, and the memory model there returns a fixed function of the address, which also lets the bench predict pointer bytes.

// File: rtl/oas_pkg.sv
package oas_pkg;

    typedef enum logic [3:0] {
        AM_IMM    = 4'd0,
        AM_DP     = 4'd1,
        AM_DPI    = 4'd2,
        AM_IND    = 4'd3,
        AM_INDINC = 4'd4,
        AM_DPXIND = 4'd5,
        AM_DPINDY = 4'd6,
        AM_ABS    = 4'd7,
        AM_ABSI   = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        OC_LOAD  = 2'd0,
        OC_STORE = 2'd1,
        OC_CMP   = 2'd2
    } opcls_e;

    typedef enum logic [3:0] {
        S_WAIT, S_OPC, S_IMM, S_OFF, S_ALO, S_AHI, S_GAP1,
        S_GAP2, S_PLO, S_PHI, S_RD, S_WR, S_TAIL
    } state_e;

endpackage

// File: rtl/oas_fsm.sv
module oas_fsm
    import oas_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  amode_e mode_i,
    input  opcls_e cls_i,
    output state_e state,
    output amode_e mode_q,
    output logic   done,
    output logic   wait_st
);
    state_e nxt;
    opcls_e cls_q;

    // State register and per-instruction control capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_WAIT;
            mode_q <= AM_IMM;
            cls_q  <= OC_LOAD;
        end else begin
            state <= nxt;
            if (state == S_WAIT && start) begin
                mode_q <= mode_i;
                cls_q  <= cls_i;
            end
        end
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            S_WAIT: nxt = start ? S_OPC : S_WAIT;
            S_OPC: begin
                case (mode_q)
                    AM_DP, AM_DPI, AM_DPXIND, AM_DPINDY: nxt = S_OFF;
                    AM_IND, AM_INDINC:                   nxt = S_GAP1;
                    AM_ABS, AM_ABSI:                     nxt = S_ALO;
                    default:                             nxt = S_IMM;
                endcase
            end
            S_OFF: begin
                case (mode_q)
                    AM_DPI, AM_DPXIND: nxt = S_GAP1;
                    AM_DPINDY:         nxt = S_PLO;
                    default:           nxt = S_RD;
                endcase
            end
            S_ALO:  nxt = S_AHI;
            S_AHI:  nxt = (mode_q == AM_ABSI) ? S_GAP1 : S_RD;
            S_GAP1: begin
                if (mode_q == AM_DPXIND)
                    nxt = S_PLO;
                else if (mode_q == AM_INDINC && cls_q == OC_STORE)
                    nxt = S_GAP2;
                else
                    nxt = S_RD;
            end
            S_GAP2: nxt = S_WR;
            S_PLO:  nxt = S_PHI;
            S_PHI:  nxt = (mode_q == AM_DPXIND) ? S_RD : S_GAP1;
            S_RD: begin
                if (cls_q == OC_STORE)
                    nxt = S_WR;
                else if (cls_q == OC_CMP || mode_q == AM_INDINC)
                    nxt = S_TAIL;
                else
                    nxt = S_WAIT;
            end
            S_IMM, S_WR, S_TAIL: nxt = S_WAIT;
            default: nxt = S_WAIT;
        endcase
    end

    // Control outputs
    always_comb begin
        wait_st = (state == S_WAIT);
        unique case (state)
            S_IMM, S_WR, S_TAIL: done = 1'b1;
            S_RD: done = (cls_q == OC_LOAD) && (mode_q != AM_INDINC);
            default: done = 1'b0;
        endcase
    end

endmodule

// File: rtl/oas_capture.sv
module oas_capture
    import oas_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  state_e        state,
    input  logic [AW-1:0] pc_i,
    input  logic          page_i,
    input  logic          isel_i,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] pc_q,
    output logic          page_q,
    output logic          isel_q,
    output logic [DW-1:0] off_q,
    output logic [DW-1:0] lo_q,
    output logic [DW-1:0] hi_q,
    output logic [DW-1:0] operand
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            page_q  <= 1'b0;
            isel_q  <= 1'b0;
            off_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            operand <= '0;
        end else begin
            if (accept) begin
                pc_q   <= pc_i;
                page_q <= page_i;
                isel_q <= isel_i;
            end
            if (state == S_OFF)                     off_q   <= rdata;
            if (state == S_ALO || state == S_PLO)   lo_q    <= rdata;
            if (state == S_AHI || state == S_PHI)   hi_q    <= rdata;
            if (state == S_IMM || state == S_RD)    operand <= rdata;
        end
    end
endmodule

// File: rtl/oas_agen.sv
module oas_agen
    import oas_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  state_e        state,
    input  amode_e        mode_q,
    input  logic [AW-1:0] pc_q,
    input  logic          page_q,
    input  logic          isel_q,
    input  logic [DW-1:0] x_reg,
    input  logic [DW-1:0] y_reg,
    input  logic [DW-1:0] off_q,
    input  logic [DW-1:0] lo_q,
    input  logic [DW-1:0] hi_q,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic          idle
);
    localparam int PW = DW + 1;

    logic [AW-1:0] dp_base, ea, ptr_lo, ptr_hi, word;
    logic [DW-1:0] idx, idx_sum, xptr, ptr_off;

    always_comb begin
        dp_base = AW'({page_q, {DW{1'b0}}});
        idx     = isel_q ? y_reg : x_reg;
        idx_sum = off_q + idx;
        xptr    = off_q + x_reg;
        word    = AW'({hi_q, lo_q});
        ptr_off = (mode_q == AM_DPXIND) ? xptr : off_q;
        ptr_lo  = dp_base | AW'(ptr_off);
        ptr_hi  = dp_base | AW'(ptr_off + DW'(1));
        case (mode_q)
            AM_DP:             ea = dp_base | AW'(off_q);
            AM_DPI:            ea = dp_base | AW'(idx_sum);
            AM_IND, AM_INDINC: ea = dp_base | AW'(x_reg);
            AM_DPXIND, AM_ABS: ea = word;
            AM_DPINDY:         ea = word + AW'(y_reg);
            AM_ABSI:           ea = word + AW'(idx);
            default:           ea = pc_q + AW'(1);
        endcase
    end

    always_comb begin
        rw   = (state != S_WR);
        idle = 1'b0;
        unique case (state)
            S_WAIT:              begin addr = pc_q; idle = 1'b1; end
            S_OPC:               addr = pc_q;
            S_IMM, S_OFF, S_ALO: addr = pc_q + AW'(1);
            S_AHI:               addr = pc_q + AW'(2);
            S_PLO:               addr = ptr_lo;
            S_PHI:               addr = ptr_hi;
            S_GAP1, S_GAP2, S_TAIL: begin addr = ea; idle = 1'b1; end
            S_RD, S_WR:          addr = ea;
            default:             begin addr = pc_q; idle = 1'b1; end
        endcase
    end

    logic unused_pw;
    assign unused_pw = (PW == 0);
endmodule

// File: rtl/oas_seq.sv
module oas_seq
    import oas_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [1:0]    op_cls,
    input  logic          idx_sel,
    input  logic [AW-1:0] pc,
    input  logic          page,
    input  logic [DW-1:0] x_reg,
    input  logic [DW-1:0] y_reg,
    input  logic [DW-1:0] st_data,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic          idle,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] operand,
    output logic          done
);
    state_e        state;
    amode_e        mode_q;
    logic          wait_st;
    logic [AW-1:0] pc_q;
    logic          page_q, isel_q;
    logic [DW-1:0] off_q, lo_q, hi_q;

    oas_fsm u_fsm (
        .clk, .rst_n, .start,
        .mode_i (amode_e'(mode)),
        .cls_i  (opcls_e'(op_cls)),
        .state, .mode_q, .done, .wait_st
    );

    oas_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk, .rst_n,
        .accept (wait_st && start),
        .state,
        .pc_i   (pc),
        .page_i (page),
        .isel_i (idx_sel),
        .rdata,
        .pc_q, .page_q, .isel_q, .off_q, .lo_q, .hi_q, .operand
    );

    oas_agen #(.AW(AW), .DW(DW)) u_agen (
        .state, .mode_q, .pc_q, .page_q, .isel_q,
        .x_reg, .y_reg, .off_q, .lo_q, .hi_q,
        .addr, .rw, .idle
    );

    assign wdata = rw ? '0 : st_data;
endmodule

// File: rtl/oas_chk.sv
module oas_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          wait_st,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] addr,
    input logic          rw,
    input logic          idle,
    input logic          done
);
    // R12: idle cycles never drive a write
    a_r12_idle_reads: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> rw);

    // R9: a write that follows a non-idle cycle repeats that cycle's read address
    a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rw && !$past(idle)) |-> ($past(rw) && $past(addr) == addr));

    // R13: done lasts one cycle
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: a write only happens on the last cycle
    a_r13_write_last: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> done);

    // R1: the cycle after a launch is the opcode read at the sampled pc
    a_r1_opcode_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wait_st) |=> (addr == $past(pc) && rw && !idle));
endmodule

bind oas_seq oas_chk #(.AW(AW)) u_chk (
    .clk, .rst_n, .start, .wait_st, .pc, .addr, .rw, .idle, .done
);

// File: tb/oas_seq_tb_top.sv
module oas_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  op_cls = '0;
    logic        idx_sel = 1'b0, page = 1'b0;
    logic [15:0] pc = '0, addr;
    logic [7:0]  x_reg = '0, y_reg = '0, st_data = '0, rdata, wdata, operand;
    logic        rw, idle, done;

    int checks = 0, fails = 0;

    logic [15:0] e_addr [0:9];
    logic        e_rw   [0:9];
    logic        e_idl  [0:9];
    int          e_n;
    logic        e_chkop;
    logic [7:0]  e_op;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign rdata = mem(addr);

    oas_seq dut_i (
        .clk, .rst_n, .start, .mode, .op_cls, .idx_sel, .pc, .page,
        .x_reg, .y_reg, .st_data, .rdata,
        .addr, .rw, .idle, .wdata, .operand, .done
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic r, input logic i);
        e_addr[e_n] = a; e_rw[e_n] = r; e_idl[e_n] = i; e_n++;
    endtask

    // Build the expected trace from the requirement rules
    task automatic build(input logic [3:0] m, input logic [1:0] c, input logic s);
        logic [15:0] base, ea;
        logic [7:0]  off, idx, pl, lo, hi;
        e_n = 0; e_chkop = 1'b1;
        base = page ? 16'h0100 : 16'h0000;
        idx  = s ? y_reg : x_reg;
        off  = mem(pc + 16'd1);
        push(pc, 1, 0);
        case (m)
            4'd0: begin push(pc + 16'd1, 1, 0); e_op = off; return; end
            4'd1: begin push(pc + 16'd1, 1, 0); ea = base | {8'h0, off}; end
            4'd2: begin push(pc + 16'd1, 1, 0); push(0, 1, 1);
                        ea = base | {8'h0, 8'(off + idx)}; end
            4'd3: begin push(0, 1, 1); ea = base | {8'h0, x_reg}; end
            4'd4: begin
                ea = base | {8'h0, x_reg};
                push(0, 1, 1);
                if (c == 2'd1) begin
                    push(0, 1, 1); push(ea, 0, 0); e_chkop = 1'b0;
                end else begin
                    push(ea, 1, 0); push(0, 1, 1); e_op = mem(ea);
                end
                return;
            end
            4'd5: begin
                pl = off + x_reg;
                lo = mem(base | {8'h0, pl});
                hi = mem(base | {8'h0, 8'(pl + 8'd1)});
                push(pc + 16'd1, 1, 0); push(0, 1, 1);
                push(base | {8'h0, pl}, 1, 0);
                push(base | {8'h0, 8'(pl + 8'd1)}, 1, 0);
                ea = {hi, lo};
            end
            4'd6: begin
                lo = mem(base | {8'h0, off});
                hi = mem(base | {8'h0, 8'(off + 8'd1)});
                push(pc + 16'd1, 1, 0);
                push(base | {8'h0, off}, 1, 0);
                push(base | {8'h0, 8'(off + 8'd1)}, 1, 0);
                push(0, 1, 1);
                ea = {hi, lo} + {8'h0, y_reg};
            end
            default: begin
                lo = off; hi = mem(pc + 16'd2);
                push(pc + 16'd1, 1, 0); push(pc + 16'd2, 1, 0);
                ea = {hi, lo};
                if (m == 4'd8) begin push(0, 1, 1); ea = ea + {8'h0, idx}; end
            end
        endcase
        push(ea, 1, 0);
        e_op = mem(ea);
        if (c == 2'd1) push(ea, 0, 0);
        if (c == 2'd2) push(0, 1, 1);
    endtask

    // Launch, then compare each trace cycle on its falling edge
    task automatic run(input string req, input logic [3:0] m, input logic [1:0] c,
                       input logic s, input bit poke);
        build(m, c, s);
        @(negedge clk);
        mode = m; op_cls = c; idx_sel = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < e_n; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == 1) begin start = 1'b1; pc = pc ^ 16'h0F0F; end
            if (poke && k == 2) start = 1'b0;
            check(rw == e_rw[k], "R12", $sformatf("%s rw c%0d", req, k + 1), rw, e_rw[k]);
            check(idle == e_idl[k], "R12", $sformatf("%s idle c%0d", req, k + 1), idle, e_idl[k]);
            check(done == (k == e_n - 1), "R13", $sformatf("%s done c%0d", req, k + 1),
                  done, (k == e_n - 1));
            if (!e_idl[k])
                check(addr == e_addr[k], req, $sformatf("addr c%0d", k + 1), addr, e_addr[k]);
            if (!e_rw[k])
                check(wdata == st_data, "R9", "wdata", wdata, st_data);
        end
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && idle == 1'b1, "R13", $sformatf("%s back to wait", req),
              {done, idle}, 2'b01);
        if (e_chkop) check(operand == e_op, req, "operand", operand, e_op);
    endtask

    task automatic t_reset;
        check(done == 0 && rw == 1 && idle == 1, "R14", "in reset", {done, rw, idle}, 3'b011);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && rw == 1 && idle == 1, "R14", "after reset", {done, rw, idle}, 3'b011);
    endtask

    task automatic t_imm;        pc = 16'h1234; run("R2", 4'd0, 2'd0, 0, 0); endtask
    task automatic t_direct;
        pc = 16'h2040; page = 0; run("R3", 4'd1, 2'd0, 0, 0);
        pc = 16'h3311; page = 1; run("R3", 4'd1, 2'd0, 0, 0);
    endtask
    task automatic t_dp_indexed;
        pc = 16'h00F0; page = 1; x_reg = 8'hF7; y_reg = 8'h03;
        run("R4", 4'd2, 2'd0, 0, 0);   // offset+X wraps in the page
        run("R4", 4'd2, 2'd0, 1, 0);
    endtask
    task automatic t_ind_x;      page = 0; x_reg = 8'h44; pc = 16'h4000; run("R5", 4'd3, 2'd0, 0, 0); endtask
    task automatic t_idx_ind;
        pc = 16'h5A12; page = 0; x_reg = 8'hFF; run("R6", 4'd5, 2'd0, 0, 0);
        page = 1; x_reg = 8'h10; run("R6", 4'd5, 2'd0, 0, 0);
    endtask
    task automatic t_ind_idx;
        pc = 16'h6677; page = 1; y_reg = 8'hE0; run("R7", 4'd6, 2'd0, 0, 0);
    endtask
    task automatic t_absolute;
        pc = 16'h7FFE; run("R8", 4'd7, 2'd0, 0, 0);
        x_reg = 8'hC3; y_reg = 8'h5C; pc = 16'h8123;
        run("R8", 4'd8, 2'd0, 0, 0);
        run("R8", 4'd8, 2'd0, 1, 0);
    endtask
    task automatic t_store;
        st_data = 8'h9B; page = 0; pc = 16'h9000;
        run("R9", 4'd1, 2'd1, 0, 0);
        run("R9", 4'd6, 2'd1, 0, 0);
        st_data = 8'h3C; run("R9", 4'd8, 2'd1, 0, 0);
        run("R9", 4'd3, 2'd1, 0, 0);
    endtask
    task automatic t_autoinc;
        st_data = 8'h71; x_reg = 8'h2A; page = 1; pc = 16'hA000;
        run("R10", 4'd4, 2'd1, 0, 0);
        run("R10", 4'd4, 2'd0, 0, 0);
    endtask
    task automatic t_compare;
        pc = 16'hB0B0; page = 0; run("R11", 4'd1, 2'd2, 0, 0);
        x_reg = 8'h01; run("R11", 4'd5, 2'd2, 0, 0);
    endtask
    task automatic t_busy_start;
        pc = 16'hC100; page = 0; x_reg = 8'h05;
        run("R13", 4'd5, 2'd0, 0, 1);  // start mid-trace must not disturb it
        @(negedge clk);
        check(idle == 1 && done == 0, "R13", "no relaunch", {idle, done}, 2'b10);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_imm;
        t_direct;
        t_dp_indexed;
        t_ind_x;
        t_idx_ind;
        t_ind_idx;
        t_absolute;
        t_store;
        t_autoinc;
        t_compare;
        t_busy_start;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule